// File: doc/BRIEF.md
# Guarded Frame Transmitter

This block streams one frame out of a byte buffer to a downstream modulator over a valid/ready byte handshake. Each transmission is wrapped: six zero bytes lead the frame, then the frame bytes are fetched from the buffer in address order, then two zero bytes close it. The frame bytes are opaque to the block. By convention they carry a two-byte sync word, a length byte, the payload and a two-byte CRC, but no field is decoded.

A transmission does not begin when it is requested. The block runs a free-running tick counter and keeps a "not before" time. That time is raised by a guard interval after every transmission start. It is also raised by a shorter turnaround interval whenever the receiver reports the end of a reception.

When a request is taken, the start time is fixed as follows:
- take the later of the not-before time and the current tick;
- round it down to a multiple of eight;
- add eight.

The first preamble byte is offered in the cycle whose tick equals that start time.

Top module: `guarded_frame_tx`

## Requirements
- R1: Every transmission begins with six bytes of value 0x00 on `tx_data_o`, ahead of any buffer byte.
- R2: After the preamble, the `frame_len_i` bytes are sent from buffer addresses 0 to `frame_len_i`-1 in ascending order. The read port is combinational: `rd_data_i` answers `rd_addr_o` in the same cycle.
- R3: After the last buffer byte, exactly two bytes of value 0x00 are sent.
- R4: A byte is transferred only in a cycle where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, the offered byte and `tx_valid_o` are held.
- R5: The tick counter reads 0 in the first cycle after reset is released and then rises by one per clock. A request seen in the cycle with tick N gets start time S = (max(A, N) with bits [2:0] cleared) + 8, where A is the not-before time. `tx_valid_o` first rises in the cycle whose tick equals S.
- R6: In the cycle in which a transmission starts at time S, the not-before time becomes at least S + 426.
- R7: A one-cycle `rx_done_i` pulse in the cycle with tick T raises the not-before time to at least T + 168.
- R8: Reset sets the not-before time to 0, so a first request at tick N < 8 starts at tick 8.
- R9: `busy_o` rises in the cycle after a request is taken. It stays high up to and including the cycle in which the last padding byte is accepted, and is low in the cycle after. A request made while `busy_o` is high is ignored and has no effect on the bytes sent.
- R10: While reset is asserted and right after it, `busy_o` and `tx_valid_o` are low.
- R11: With a frame length of 0, exactly eight bytes of 0x00 are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the tick counter advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to transmit the buffered frame |
| frame_len_i | input | LEN_W | Number of buffer bytes in the frame, sampled with the request |
| rd_addr_o | output | LEN_W | Buffer read address |
| rd_data_i | input | 8 | Buffer read data for `rd_addr_o`, same cycle |
| tx_data_o | output | 8 | Byte offered to the modulator |
| tx_valid_o | output | 1 | `tx_data_o` holds a byte to transfer |
| tx_ready_i | input | 1 | Modulator takes the offered byte this cycle |
| rx_done_i | input | 1 | Single-cycle pulse: a reception has just completed |
| busy_o | output | 1 | A transmission is pending or in progress |

## Verification
A wrong not-before value or a wrong captured start time does not show up when it is written. It first appears at the next launch, as `tx_valid_o` rising on the wrong tick, which can be several hundred cycles later. For that reason the bench compares the valid timing on every clock against a reference that tracks the not-before time itself. A wrong byte position shows at once as a wrong data value or a wrong frame length. A busy flag that stays stuck, or a start request that leaks through while busy, shows as a byte stream of the wrong size within one frame.

// File: rtl/gft_pkg.sv
package gft_pkg;

  // Sequencer phase: idle, waiting for the scheduled tick, streaming bytes.
  typedef enum logic [1:0] {
    GFT_IDLE = 2'd0,
    GFT_WAIT = 2'd1,
    GFT_SEND = 2'd2
  } gft_phase_e;

  // Value carried by every preamble and padding byte.
  localparam logic [7:0] GFT_FILL_BYTE = 8'h00;

endpackage

// File: rtl/gft_tick_sched.sv
module gft_tick_sched #(
  parameter int TICK_W            = 32,
  parameter int ALIGN_LOG2        = 3,
  parameter int GUARD_TICKS       = 426,
  parameter int FRAME_DELAY_TICKS = 168
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,      // request accepted this cycle
  input  logic waiting_i,  // sequencer holds a pending request
  input  logic rx_done_i,  // reception finished this cycle
  output logic launch_o    // scheduled start tick reached
);

  localparam logic [TICK_W-1:0] STEP   = TICK_W'(1 << ALIGN_LOG2);
  localparam logic [TICK_W-1:0] GRID   = ~(STEP - TICK_W'(1));
  localparam logic [TICK_W-1:0] GUARD  = TICK_W'(GUARD_TICKS);
  localparam logic [TICK_W-1:0] FDELAY = TICK_W'(FRAME_DELAY_TICKS);

  logic [TICK_W-1:0] now_q;
  logic [TICK_W-1:0] allow_q;
  logic [TICK_W-1:0] allow_d;
  logic [TICK_W-1:0] target_q;

  function automatic logic [TICK_W-1:0] later_of(
    input logic [TICK_W-1:0] a,
    input logic [TICK_W-1:0] b
  );
    return (a > b) ? a : b;
  endfunction

  // First grid slot strictly after the later of the floor and the current tick.
  function automatic logic [TICK_W-1:0] next_slot(
    input logic [TICK_W-1:0] floor_t,
    input logic [TICK_W-1:0] cur_t
  );
    return (later_of(floor_t, cur_t) & GRID) + STEP;
  endfunction

  assign launch_o = waiting_i && (now_q == target_q);

  always_comb begin
    allow_d = allow_q;
    if (launch_o)  allow_d = later_of(allow_d, target_q + GUARD);
    if (rx_done_i) allow_d = later_of(allow_d, now_q + FDELAY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q    <= '0;
      allow_q  <= '0;
      target_q <= '0;
    end else begin
      now_q   <= now_q + TICK_W'(1);
      allow_q <= allow_d;
      if (arm_i) target_q <= next_slot(allow_q, now_q);
    end
  end

  // R5: launches only happen on grid ticks
  a_r5_launch_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |-> ((now_q & ~GRID) == '0));

  // R6: the guard window is in place right after a launch
  a_r6_guard_floor: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> (allow_q >= $past(now_q) + GUARD));

  // R7: the turnaround window is in place right after a reception ends
  a_r7_rx_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> (allow_q >= $past(now_q) + FDELAY));

  // R8: the not-before time never moves backwards
  a_r8_allow_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (allow_q >= $past(allow_q)));

  // R5: a captured start lies in the future of the request tick
  a_r5_target_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (target_q > $past(now_q)));

endmodule

// File: rtl/gft_byte_seq.sv
module gft_byte_seq
  import gft_pkg::*;
#(
  parameter int LEN_W     = 9,
  parameter int PRE_BYTES = 6,
  parameter int PAD_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             launch_i,
  output logic             arm_o,
  output logic             waiting_o,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic             busy_o
);

  localparam int POS_W = LEN_W + 2;
  localparam logic [POS_W-1:0] PRE_N = POS_W'(PRE_BYTES);
  localparam logic [POS_W-1:0] PAD_N = POS_W'(PAD_BYTES);

  gft_phase_e       phase_q, phase_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] len_q, len_d;

  logic [POS_W-1:0] body_end;
  logic             in_body;
  logic             accept;
  logic             last_byte;

  assign body_end  = PRE_N + POS_W'(len_q);
  assign in_body   = (pos_q >= PRE_N) && (pos_q < body_end);
  assign last_byte = (pos_q == body_end + PAD_N - POS_W'(1));

  assign rd_addr_o  = in_body ? LEN_W'(pos_q - PRE_N) : '0;
  assign tx_data_o  = in_body ? rd_data_i : GFT_FILL_BYTE;
  assign tx_valid_o = (phase_q == GFT_SEND) || ((phase_q == GFT_WAIT) && launch_i);
  assign accept     = tx_valid_o && tx_ready_i;
  assign busy_o     = (phase_q != GFT_IDLE);
  assign waiting_o  = (phase_q == GFT_WAIT);
  assign arm_o      = (phase_q == GFT_IDLE) && start_i;

  always_comb begin
    phase_d = phase_q;
    pos_d   = pos_q;
    len_d   = len_q;
    case (phase_q)
      GFT_IDLE: if (start_i) begin
        phase_d = GFT_WAIT;
        pos_d   = '0;
        len_d   = frame_len_i;
      end
      GFT_WAIT: if (launch_i) phase_d = GFT_SEND;
      default: ;
    endcase
    if (accept) begin
      if (last_byte) begin
        phase_d = GFT_IDLE;
        pos_d   = '0;
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= GFT_IDLE;
      pos_q   <= '0;
      len_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
    end
  end

  // R9: busy only drops right after the final padding byte was taken
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(accept && last_byte));

  // R4: an offered byte stays offered, at the same position, until taken
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(pos_q)));

  // R9: a request while busy leaves the latched length alone
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(len_q));

  // R4: bytes are only offered while a transmission is pending
  a_r4_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> busy_o);

endmodule

// File: rtl/guarded_frame_tx.sv
module guarded_frame_tx
  import gft_pkg::*;
#(
  parameter int LEN_W             = 9,
  parameter int TICK_W            = 32,
  parameter int ALIGN_LOG2        = 3,
  parameter int PRE_BYTES         = 6,
  parameter int PAD_BYTES         = 2,
  parameter int GUARD_TICKS       = 426,
  parameter int FRAME_DELAY_TICKS = 168
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic             rx_done_i,
  output logic             busy_o
);

  // Internal events, named so the checks below can refer to them.
  logic arm_ev;
  logic waiting_ev;
  logic launch_ev;

  gft_tick_sched #(
    .TICK_W           (TICK_W),
    .ALIGN_LOG2       (ALIGN_LOG2),
    .GUARD_TICKS      (GUARD_TICKS),
    .FRAME_DELAY_TICKS(FRAME_DELAY_TICKS)
  ) sched_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_ev),
    .waiting_i(waiting_ev),
    .rx_done_i(rx_done_i),
    .launch_o (launch_ev)
  );

  gft_byte_seq #(
    .LEN_W    (LEN_W),
    .PRE_BYTES(PRE_BYTES),
    .PAD_BYTES(PAD_BYTES)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .frame_len_i(frame_len_i),
    .launch_i   (launch_ev),
    .arm_o      (arm_ev),
    .waiting_o  (waiting_ev),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .busy_o     (busy_o)
  );

  // R1: the byte offered at launch is a preamble fill byte
  a_r1_launch_fill: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ev |-> (tx_valid_o && (tx_data_o == GFT_FILL_BYTE)));

  // R9: a taken request raises busy in the next cycle
  a_r9_busy_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ev |=> busy_o);

  // R5: no byte is offered before the scheduled launch
  a_r5_no_early_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_ev && !launch_ev) |-> !tx_valid_o);

endmodule

// File: tb/guarded_frame_tx_tb.sv
`timescale 1ns/1ps
module guarded_frame_tx_tb_top;

  localparam int LEN_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] frame_len_i = '0;
  logic [LEN_W-1:0] rd_addr_o;
  logic [7:0]       rd_data_i;
  logic [7:0]       tx_data_o;
  logic             tx_valid_o;
  logic             tx_ready_i = 1'b1;
  logic             rx_done_i = 1'b0;
  logic             busy_o;

  always #4 clk = ~clk;

  // Buffer contents: fixed sync pair, then a seeded pattern.
  logic [7:0] seed = 8'h11;
  function automatic logic [7:0] buf_byte(input int addr, input logic [7:0] s);
    if (addr == 0) return 8'hB2;
    if (addr == 1) return 8'h4D;
    return 8'((addr * 29) + s);
  endfunction
  assign rd_data_i = buf_byte(int'(rd_addr_o), seed);

  guarded_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_len_i(frame_len_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .tx_data_o(tx_data_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .rx_done_i(rx_done_i),
    .busy_o(busy_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (tick %0d)", tag, act, exp, tick);
    end
  endtask

  // ---------------- reference model ----------------
  int         tick = 0;
  bit         m_busy = 0;
  bit         m_send = 0;
  int         m_target = 0;
  int         m_na = 0;
  string      m_na_src = "R8";
  int         m_idx = 0;
  int         m_len = 0;
  logic [7:0] q[$];
  int         launch_tick[$];
  bit         rnd_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit exp_valid();
    return m_busy && (m_send || (tick == m_target));
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit busy_old;
      int na_new;
      busy_old = m_busy;
      na_new   = m_na;
      if (m_busy && !m_send && tick == m_target) begin
        if (m_target + 426 > na_new) begin na_new = m_target + 426; m_na_src = "R6"; end
      end
      if (exp_valid() && tx_ready_i) begin
        m_send = 1;
        void'(q.pop_front());
        m_idx++;
        if (q.size() == 0) begin m_busy = 0; m_send = 0; end
      end else if (m_busy && tick == m_target) begin
        m_send = 1;
      end
      if (rx_done_i && tick + 168 > na_new) begin na_new = tick + 168; m_na_src = "R7"; end
      if (!busy_old && start_i) begin
        m_busy   = 1;
        m_send   = 0;
        m_target = (max2(m_na, tick) & ~7) + 8;
        m_len    = int'(frame_len_i);
        m_idx    = 0;
        q.delete();
        for (int i = 0; i < 6; i++) q.push_back(8'h00);
        for (int i = 0; i < m_len; i++) q.push_back(buf_byte(i, seed));
        for (int i = 0; i < 2; i++) q.push_back(8'h00);
      end
      m_na = na_new;
      tick++;
    end
  end

  // Per-clock comparison, half a period away from the active edge.
  bit prev_valid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      string vtag;
      string dtag;
      if (m_send) vtag = "R4";
      else if (m_na > tick - 8) vtag = m_na_src;
      else vtag = "R5";
      chk(tx_valid_o == exp_valid(), vtag, int'(tx_valid_o), int'(exp_valid()));
      chk(busy_o == m_busy, "R9", int'(busy_o), int'(m_busy));
      if (exp_valid() && q.size() > 0) begin
        if (m_idx < 6) dtag = "R1";
        else if (m_idx < 6 + m_len) dtag = "R2";
        else if (m_len == 0) dtag = "R11";
        else dtag = "R3";
        chk(tx_data_o == q[0], dtag, int'(tx_data_o), int'(q[0]));
      end
      if (tx_valid_o && !prev_valid) launch_tick.push_back(tick);
      prev_valid = tx_valid_o;
    end
  end

  // Ready pattern driver.
  always @(negedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready_i <= rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic request(input int len, input logic [7:0] s, input bit new_seed);
    if (new_seed) seed = s;
    frame_len_i = LEN_W'(len);
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    do step(); while (busy_o || m_busy);
  endtask

  task automatic wait_until(input int t);
    while (tick < t) step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int t_rx;
    int t_req;
    int exp_t;
    repeat (3) @(negedge clk);
    // R10: quiet outputs during reset
    chk(busy_o == 1'b0, "R10", int'(busy_o), 0);
    chk(tx_valid_o == 1'b0, "R10", int'(tx_valid_o), 0);
    #1 rst_n = 1'b1;
    step();
    chk(busy_o == 1'b0 && tx_valid_o == 1'b0, "R10", int'({busy_o, tx_valid_o}), 0);
    step();

    // R8: first frame after reset starts at tick 8
    request(10, 8'h11, 1);
    wait_idle();
    chk(launch_tick.size() == 1 && launch_tick[0] == 8, "R8",
        launch_tick.size() > 0 ? launch_tick[0] : -1, 8);

    // R6: back-to-back request held by the guard interval; random ready (R4)
    rnd_ready = 1;
    request(20, 8'h37, 1);
    exp_t = ((8 + 426) & ~7) + 8;
    repeat (exp_t - tick + 5) step();
    // R9: request during the frame with another length must be ignored
    request(3, 8'h37, 0);
    wait_idle();
    chk(launch_tick.size() == 2 && launch_tick[1] == exp_t, "R6",
        launch_tick.size() > 1 ? launch_tick[1] : -1, exp_t);

    // R7: reception end pushes the next start out
    wait_until(exp_t + 440);
    t_rx = tick;
    rx_done_i = 1'b1; step(); rx_done_i = 1'b0;
    step();
    request(5, 8'h52, 1);
    wait_idle();
    exp_t = ((t_rx + 168) & ~7) + 8;
    chk(launch_tick.size() == 3 && launch_tick[2] == exp_t, "R7",
        launch_tick.size() > 2 ? launch_tick[2] : -1, exp_t);

    // R5 + R11: idle long enough, off-grid request, empty frame
    rnd_ready = 0;
    wait_until(exp_t + 700);
    while ((tick & 7) != 5) step();
    t_req = tick;
    request(0, 8'h52, 0);
    wait_idle();
    exp_t = (t_req & ~7) + 8;
    chk(launch_tick.size() == 4 && launch_tick[3] == exp_t, "R5",
        launch_tick.size() > 3 ? launch_tick[3] : -1, exp_t);

    // R7 during the wait of a frame, then a follow-up frame
    rnd_ready = 1;
    wait_until(exp_t + 600);
    request(40, 8'h6B, 1);
    rx_done_i = 1'b1; step(); rx_done_i = 1'b0;
    wait_idle();
    request(12, 8'h90, 1);
    wait_idle();
    chk(launch_tick.size() == 6, "R9", launch_tick.size(), 6);

    repeat (4) step();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule